// File: doc/BRIEF.md
# Auxiliary System Control Register Block

This block is a byte-wide register island for a workstation I/O device. Software reaches it over a simple single-cycle bus. It holds a configuration byte, two auxiliary registers, a diagnostic byte and a modem-control byte. It also decodes a write-only system-control location and an inert power-management location.

A power-fail input from board logic is first synchronised. It is then latched into a status bit of the second auxiliary register, but only while the configuration enable bit (config bit 3) is set. That status bit, qualified by the same enable, drives the interrupt line. Software clears the condition by writing a one to bit 1 of the second auxiliary register.

Two writes produce one-clock request pulses for the platform's power and reset logic. A write to the second auxiliary register with bit 0 set requests a shutdown. A write to system control with bit 0 set requests a system reset. The diagnostic byte survives a warm reset and is cleared only by a separate power-on reset.

Top module: `aux_sysctl_regs`

## Requirements
- R1: A location is selected by address bits 27:16 alone: 0x180 config, 0x190 aux-one, 0x191 aux-two, 0x1A0 diag, 0x1B0 modem control, 0x1F0 system control, 0xA00 power management. Bits 15:0 are ignored.
- R2: Config, aux-one, diag and modem control are 8-bit read/write registers. Read data appears on the cycle after the read strobe is sampled.
- R3: Reads of system control, power management or any unmapped page return 0. Writes to power management or to unmapped pages change no register.
- R4: The power-fail input passes through two synchronising flip-flops. On each change of the synchronised level, aux-two bit 2 is loaded with (level AND config bit 3). A rising input is therefore visible in aux-two three clock edges after it is sampled.
- R5: Every config write reloads aux-two bit 2 with (synchronised power-fail level AND the newly written bit 3).
- R6: The interrupt output is high exactly when aux-two bit 2 and config bit 3 are both 1.
- R7: An aux-two write stores data bits 1:0 and keeps bit 2. If written bit 1 is 1, bits 2 and 1 both become 0 and only bit 0 is kept. Aux-two reads as {5'b0, bit2, bit1, bit0}.
- R8: An aux-two write with data bit 0 set raises the shutdown request for exactly one clock, in the cycle after the write edge. No other write raises it.
- R9: A system-control write with data bit 0 set raises the system-reset request for exactly one clock, in the cycle after the write edge. No other write raises it.
- R10: The synchronous active-low warm reset clears config, aux-one, aux-two, modem control, read data and both requests, and leaves diag unchanged. The power-on reset clears diag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low warm reset |
| por_n | input | 1 | Synchronous active-low power-on reset, clears diag only |
| bus_addr | input | 28 | Byte address; bits 27:16 pick the location |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pwr_fail_in | input | 1 | Asynchronous power-fail condition |
| irq_out | output | 1 | Power-fail interrupt |
| shutdown_req | output | 1 | One-clock shutdown request |
| sysreset_req | output | 1 | One-clock system-reset request |

## Verification
The bench first targets the enable gating of the status bit. It raises power-fail with the enable clear, and later sets the enable while power-fail is held high. A design that latched the raw condition, or one that re-evaluated only on input edges, would either interrupt with the enable off or never interrupt at all.

It writes aux-two with bits 1 and 0 both set and expects the status bit cleared and bit 0 kept. A design that stored the data as-is would read back 0x03 or 0x07 and keep the interrupt high.

It uses aliased low address bits and pages one step away from a mapped one, which catches a decoder that compares too few or too many bits. It also applies a warm reset with a known diag value, which exposes a diag register wired to the wrong reset.

// File: rtl/aux_sysctl_pkg.sv
// Package: shared widths, page codes and the location-select type for the
// auxiliary system control register block.
package aux_sysctl_pkg;

    localparam int ADDR_W   = 28;
    localparam int DATA_W   = 8;
    localparam int PAGE_LSB = 16;
    localparam int PAGE_W   = ADDR_W - PAGE_LSB;

    // Page codes seen in address bits 27:16
    localparam logic [11:0] PG_CFG   = 12'h180;
    localparam logic [11:0] PG_AUX1  = 12'h190;
    localparam logic [11:0] PG_AUX2  = 12'h191;
    localparam logic [11:0] PG_DIAG  = 12'h1A0;
    localparam logic [11:0] PG_MCTRL = 12'h1B0;
    localparam logic [11:0] PG_SYS   = 12'h1F0;
    localparam logic [11:0] PG_PWR   = 12'hA00;

    // Bit positions that the control logic interprets
    localparam int CFG_PF_EN_BIT = 3;
    localparam int AUX2_OFF_BIT  = 0;
    localparam int AUX2_CLR_BIT  = 1;
    localparam int AUX2_PF_BIT   = 2;
    localparam int SYS_RST_BIT   = 0;

    typedef enum logic [2:0] {
        SEL_NONE  = 3'd0,
        SEL_CFG   = 3'd1,
        SEL_AUX1  = 3'd2,
        SEL_AUX2  = 3'd3,
        SEL_DIAG  = 3'd4,
        SEL_MCTRL = 3'd5,
        SEL_SYS   = 3'd6,
        SEL_PWR   = 3'd7
    } loc_sel_e;

endpackage

// File: rtl/aux_pf_sync.sv
// Module: aux_pf_sync
// Brings the asynchronous power-fail input into the clock domain through a
// chain of STAGES flip-flops and flags each change of the synchronised level.
// Assumes STAGES >= 2 and that the input is held for several clocks.
module aux_pf_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic level,
    output logic change
);

    logic [STAGES-1:0] chain_q;
    logic              level_d_q;

    // Shift the raw input through the synchroniser chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], async_in};
        end
    end

    // Remember the previous synchronised level for change detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_d_q <= 1'b0;
        end else begin
            level_d_q <= chain_q[STAGES-1];
        end
    end

    assign level  = chain_q[STAGES-1];
    assign change = chain_q[STAGES-1] ^ level_d_q;

endmodule

// File: rtl/aux_addr_dec.sv
// Module: aux_addr_dec
// Maps the page field of the bus address onto a location select.
// Assumes the page field is the address above bit PAGE_LSB; all lower bits
// have been stripped by the caller.
module aux_addr_dec
    import aux_sysctl_pkg::*;
#(
    parameter int PW = PAGE_W
) (
    input  logic [PW-1:0] page,
    output loc_sel_e      sel
);

    // Compare the page against each mapped code
    always_comb begin
        if      (page == PW'(PG_CFG))   sel = SEL_CFG;
        else if (page == PW'(PG_AUX1))  sel = SEL_AUX1;
        else if (page == PW'(PG_AUX2))  sel = SEL_AUX2;
        else if (page == PW'(PG_DIAG))  sel = SEL_DIAG;
        else if (page == PW'(PG_MCTRL)) sel = SEL_MCTRL;
        else if (page == PW'(PG_SYS))   sel = SEL_SYS;
        else if (page == PW'(PG_PWR))   sel = SEL_PWR;
        else                            sel = SEL_NONE;
    end

endmodule

// File: rtl/aux_ctrl_regs.sv
// Module: aux_ctrl_regs
// Storage for the control registers, the gated power-fail status bit and the
// request pulse generators. Assumes one write per cycle, already decoded.
module aux_ctrl_regs
    import aux_sysctl_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          por_n,
    input  logic          wr,
    input  loc_sel_e      sel,
    input  logic [DW-1:0] wdata,
    input  logic          pf_level,
    input  logic          pf_change,
    output logic [DW-1:0] cfg,
    output logic [DW-1:0] aux1,
    output logic [2:0]    aux2,
    output logic [DW-1:0] diag,
    output logic [DW-1:0] mctrl,
    output logic          shutdown,
    output logic          sysreset
);

    logic [DW-1:0] cfg_r, aux1_r, diag_r, mctrl_r;
    logic [2:0]    aux2_r, aux2_nxt;
    logic          pf_bit_nxt;
    logic          wr_cfg, wr_aux2;

    assign wr_cfg  = wr && (sel == SEL_CFG);
    assign wr_aux2 = wr && (sel == SEL_AUX2);

    // Plain byte registers cleared by warm reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_r   <= '0;
            aux1_r  <= '0;
            mctrl_r <= '0;
        end else if (wr) begin
            if (sel == SEL_CFG)   cfg_r   <= wdata;
            if (sel == SEL_AUX1)  aux1_r  <= wdata;
            if (sel == SEL_MCTRL) mctrl_r <= wdata;
        end
    end

    // Diagnostic byte: only the power-on reset clears it
    always_ff @(posedge clk) begin
        if (!por_n) begin
            diag_r <= '0;
        end else if (wr && (sel == SEL_DIAG)) begin
            diag_r <= wdata;
        end
    end

    // Next value of the status bit: input change first, config write last
    always_comb begin
        pf_bit_nxt = aux2_r[AUX2_PF_BIT];
        if (pf_change) pf_bit_nxt = pf_level & cfg_r[CFG_PF_EN_BIT];
        if (wr_cfg)    pf_bit_nxt = pf_level & wdata[CFG_PF_EN_BIT];
    end

    // Next value of aux-two including the write-one-to-clear behaviour
    always_comb begin
        aux2_nxt = {pf_bit_nxt, aux2_r[1:0]};
        if (wr_aux2) begin
            if (wdata[AUX2_CLR_BIT]) aux2_nxt = {2'b00, wdata[AUX2_OFF_BIT]};
            else                     aux2_nxt = {pf_bit_nxt, wdata[1:0]};
        end
    end

    // Aux-two register
    always_ff @(posedge clk) begin
        if (!rst_n) aux2_r <= '0;
        else        aux2_r <= aux2_nxt;
    end

    // One-clock request pulses following the causing write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shutdown <= 1'b0;
            sysreset <= 1'b0;
        end else begin
            shutdown <= wr_aux2 && wdata[AUX2_OFF_BIT];
            sysreset <= wr && (sel == SEL_SYS) && wdata[SYS_RST_BIT];
        end
    end

    assign cfg   = cfg_r;
    assign aux1  = aux1_r;
    assign aux2  = aux2_r;
    assign diag  = diag_r;
    assign mctrl = mctrl_r;

endmodule

// File: rtl/aux_sysctl_regs.sv
// Module: aux_sysctl_regs (top)
// Byte-wide auxiliary system control register block on a single-cycle bus.
// Assumes bus_wr and bus_rd are single-cycle strobes; a read in the same cycle
// as a write to the same location returns the value before the write.
module aux_sysctl_regs
    import aux_sysctl_pkg::*;
#(
    parameter int AW        = ADDR_W,
    parameter int DW        = DATA_W,
    parameter int PLSB      = PAGE_LSB,
    parameter int PF_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          por_n,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          pwr_fail_in,
    output logic          irq_out,
    output logic          shutdown_req,
    output logic          sysreset_req
);

    localparam int PW = AW - PLSB;

    loc_sel_e      sel;
    logic          pf_level, pf_change;
    logic [DW-1:0] cfg_q, aux1_q, diag_q, mctrl_q;
    logic [2:0]    aux2_q;
    logic [DW-1:0] rdata_q;
    logic          unused_addr_low;

    assign unused_addr_low = ^bus_addr[PLSB-1:0];

    aux_addr_dec #(.PW(PW)) i_dec (
        .page (bus_addr[AW-1:PLSB]),
        .sel  (sel)
    );

    aux_pf_sync #(.STAGES(PF_STAGES)) i_pf (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pwr_fail_in),
        .level    (pf_level),
        .change   (pf_change)
    );

    aux_ctrl_regs #(.DW(DW)) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .por_n     (por_n),
        .wr        (bus_wr),
        .sel       (sel),
        .wdata     (bus_wdata),
        .pf_level  (pf_level),
        .pf_change (pf_change),
        .cfg       (cfg_q),
        .aux1      (aux1_q),
        .aux2      (aux2_q),
        .diag      (diag_q),
        .mctrl     (mctrl_q),
        .shutdown  (shutdown_req),
        .sysreset  (sysreset_req)
    );

    // Registered read multiplexer; quiet locations return zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (bus_rd) begin
            case (sel)
                SEL_CFG:   rdata_q <= cfg_q;
                SEL_AUX1:  rdata_q <= aux1_q;
                SEL_AUX2:  rdata_q <= DW'(aux2_q);
                SEL_DIAG:  rdata_q <= diag_q;
                SEL_MCTRL: rdata_q <= mctrl_q;
                default:   rdata_q <= '0;
            endcase
        end
    end

    assign bus_rdata = rdata_q;
    assign irq_out   = aux2_q[AUX2_PF_BIT] & cfg_q[CFG_PF_EN_BIT];

endmodule

// File: rtl/aux_sysctl_chk.sv
// Module: aux_sysctl_chk
// Property checker for aux_sysctl_regs, attached by the bind below. Observes
// the bus, the request outputs and the enable and status bits.
module aux_sysctl_chk
    import aux_sysctl_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [PAGE_W-1:0] page,
    input logic             bus_wr,
    input logic             bus_rd,
    input logic [1:0]       wdata_lo,
    input logic [DATA_W-1:0] bus_rdata,
    input logic             irq_out,
    input logic             shutdown_req,
    input logic             sysreset_req,
    input logic             cfg_en,
    input logic             pf_bit
);

    logic rst_low_q;

    // Note that warm reset was applied at the previous edge
    always_ff @(posedge clk) rst_low_q <= !rst_n;

    a_r8_shutdown_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && page == PG_AUX2 && wdata_lo[0]) |=> shutdown_req);

    a_r8_shutdown_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown_req |-> $past(bus_wr && page == PG_AUX2 && wdata_lo[0]));

    a_r9_sysreset_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && page == PG_SYS && wdata_lo[0]) |=> sysreset_req);

    a_r9_sysreset_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        sysreset_req |-> $past(bus_wr && page == PG_SYS && wdata_lo[0]));

    a_r4_status_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        pf_bit |-> cfg_en);

    a_r7_clear_drops_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && page == PG_AUX2 && wdata_lo[1]) |=> !irq_out);

    a_r3_quiet_reads: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && (page == PG_SYS || page == PG_PWR)) |=> (bus_rdata == '0));

    a_r10_reset_clears: assert property (@(posedge clk)
        rst_low_q |-> (!cfg_en && !pf_bit && !shutdown_req && !sysreset_req && bus_rdata == '0));

endmodule

bind aux_sysctl_regs aux_sysctl_chk i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .page         (bus_addr[27:16]),
    .bus_wr       (bus_wr),
    .bus_rd       (bus_rd),
    .wdata_lo     (bus_wdata[1:0]),
    .bus_rdata    (bus_rdata),
    .irq_out      (irq_out),
    .shutdown_req (shutdown_req),
    .sysreset_req (sysreset_req),
    .cfg_en       (cfg_q[3]),
    .pf_bit       (aux2_q[2])
);

// File: tb/test_aux_sysctl_regs.sv
`timescale 1ns/1ps
// Bench for aux_sysctl_regs: read expectations go through a scoreboard queue,
// outputs are sampled on the falling edge, inputs are driven on it.
module test_aux_sysctl_regs;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } rd_item_t;

    localparam logic [27:0] A_CFG   = 28'h180_0000;
    localparam logic [27:0] A_AUX1  = 28'h190_0000;
    localparam logic [27:0] A_AUX2  = 28'h191_0000;
    localparam logic [27:0] A_DIAG  = 28'h1A0_0000;
    localparam logic [27:0] A_MCTRL = 28'h1B0_0000;
    localparam logic [27:0] A_SYS   = 28'h1F0_0000;
    localparam logic [27:0] A_PWR   = 28'hA00_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0, por_n = 1'b0;
    logic [27:0] bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        pwr_fail_in = 1'b0;
    logic        irq_out, shutdown_req, sysreset_req;

    int checks = 0, errors = 0;
    bit done = 1'b0;
    rd_item_t sb[$];
    logic rd_seen = 1'b0;

    always #4 clk = ~clk;

    aux_sysctl_regs i_aux_sysctl_regs (
        .clk(clk), .rst_n(rst_n), .por_n(por_n), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .pwr_fail_in(pwr_fail_in), .irq_out(irq_out),
        .shutdown_req(shutdown_req), .sysreset_req(sysreset_req)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    // Driver: one write cycle, returns on the falling edge after it
    task automatic wr_reg(input logic [27:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    // Driver: one read cycle, expectation pushed to the scoreboard
    task automatic rd_reg(input logic [27:0] a, input logic [7:0] e, input string tag);
        rd_item_t it;
        it.exp = e; it.tag = tag;
        sb.push_back(it);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: note sampled read strobes, compare data on the next falling edge
    always @(posedge clk) rd_seen <= bus_rd;
    always @(negedge clk) begin
        if (rd_seen) begin
            if (sb.size() == 0) begin
                checks++; errors++;
                $display("FAIL R2: unexpected read data %02h, expected none", bus_rdata);
            end else begin
                rd_item_t it;
                it = sb.pop_front();
                check(it.tag, bus_rdata, it.exp);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        idle(3);
        rst_n = 1'b1; por_n = 1'b1;
        idle(1);
        // R10 reset state
        check("R10 irq after reset", {7'd0, irq_out}, 8'h00);
        check("R10 shutdown after reset", {7'd0, shutdown_req}, 8'h00);
        check("R10 sysreset after reset", {7'd0, sysreset_req}, 8'h00);
        rd_reg(A_CFG, 8'h00, "R10 cfg after reset");
        rd_reg(A_AUX2, 8'h00, "R10 aux2 after reset");
        rd_reg(A_DIAG, 8'h00, "R10 diag after power-on");

        // R2 plain registers
        wr_reg(A_AUX1, 8'h3C);
        wr_reg(A_MCTRL, 8'h81);
        wr_reg(A_DIAG, 8'h5A);
        wr_reg(A_CFG, 8'hA5);
        rd_reg(A_AUX1, 8'h3C, "R2 aux1");
        rd_reg(A_MCTRL, 8'h81, "R2 mctrl");
        rd_reg(A_DIAG, 8'h5A, "R2 diag");
        rd_reg(A_CFG, 8'hA5, "R2 cfg");

        // R1 low address bits ignored, neighbour pages not selected
        wr_reg(28'h180_BEEF, 8'h72);
        rd_reg(28'h180_0001, 8'h72, "R1 cfg alias");
        wr_reg(28'h181_0000, 8'hFF);
        wr_reg(28'h192_0000, 8'hFF);
        rd_reg(A_CFG, 8'h72, "R1 neighbour page no write");
        rd_reg(28'h181_0000, 8'h00, "R1 unmapped neighbour reads zero");

        // R3 quiet locations
        wr_reg(A_PWR, 8'hFF);
        rd_reg(A_PWR, 8'h00, "R3 pwr read");
        rd_reg(A_SYS, 8'h00, "R3 sysctl read");
        rd_reg(A_CFG, 8'h72, "R3 cfg untouched");
        rd_reg(A_AUX1, 8'h3C, "R3 aux1 untouched");

        // R9 system reset pulse
        wr_reg(A_SYS, 8'h01);
        check("R9 pulse high", {7'd0, sysreset_req}, 8'h01);
        idle(1);
        check("R9 pulse one clock", {7'd0, sysreset_req}, 8'h00);
        wr_reg(A_SYS, 8'hFE);
        check("R9 no pulse for bit0 clear", {7'd0, sysreset_req}, 8'h00);

        // R8 shutdown pulse and R7 aux2 storage
        wr_reg(A_AUX2, 8'h01);
        check("R8 pulse high", {7'd0, shutdown_req}, 8'h01);
        idle(1);
        check("R8 pulse one clock", {7'd0, shutdown_req}, 8'h00);
        rd_reg(A_AUX2, 8'h01, "R7 aux2 bit0 stored");
        wr_reg(A_AUX2, 8'hFC);
        check("R8 no pulse for bit0 clear", {7'd0, shutdown_req}, 8'h00);
        rd_reg(A_AUX2, 8'h00, "R7 only bits 1:0 stored");

        // R4 / R6 power-fail with enable set
        wr_reg(A_CFG, 8'h08);
        pwr_fail_in = 1'b1;
        idle(2);
        check("R4 not yet visible after two edges", {7'd0, irq_out}, 8'h00);
        idle(1);
        check("R6 irq after three edges", {7'd0, irq_out}, 8'h01);
        rd_reg(A_AUX2, 8'h04, "R4 status set");
        pwr_fail_in = 1'b0;
        idle(4);
        check("R6 irq falls with input", {7'd0, irq_out}, 8'h00);
        rd_reg(A_AUX2, 8'h00, "R4 status cleared on fall");

        // R4 gated by enable, R5 config write re-evaluates
        wr_reg(A_CFG, 8'hF7);
        pwr_fail_in = 1'b1;
        idle(4);
        rd_reg(A_AUX2, 8'h00, "R4 enable clear blocks status");
        check("R6 no irq with enable clear", {7'd0, irq_out}, 8'h00);
        wr_reg(A_CFG, 8'h08);
        check("R5 irq after enabling config write", {7'd0, irq_out}, 8'h01);
        rd_reg(A_AUX2, 8'h04, "R5 status reloaded");
        wr_reg(A_CFG, 8'h00);
        check("R5 irq drops on disabling write", {7'd0, irq_out}, 8'h00);
        wr_reg(A_CFG, 8'h08);
        rd_reg(A_AUX2, 8'h04, "R5 status reloaded again");

        // R7 keep bit 2, then write-one-to-clear
        wr_reg(A_AUX2, 8'h01);
        check("R8 pulse with status held", {7'd0, shutdown_req}, 8'h01);
        rd_reg(A_AUX2, 8'h05, "R7 bit2 kept on write");
        wr_reg(A_AUX2, 8'h03);
        check("R7 irq cleared", {7'd0, irq_out}, 8'h00);
        rd_reg(A_AUX2, 8'h01, "R7 clear keeps only bit0");
        idle(3);
        rd_reg(A_AUX2, 8'h01, "R7 stays cleared while input steady");
        wr_reg(A_AUX2, 8'h02);
        rd_reg(A_AUX2, 8'h00, "R7 clear with bit0 zero");

        // R10 warm reset keeps diag, power-on reset clears it
        pwr_fail_in = 1'b0;
        wr_reg(A_MCTRL, 8'h42);
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        idle(1);
        rd_reg(A_CFG, 8'h00, "R10 cfg cleared");
        rd_reg(A_AUX1, 8'h00, "R10 aux1 cleared");
        rd_reg(A_MCTRL, 8'h00, "R10 mctrl cleared");
        rd_reg(A_DIAG, 8'h5A, "R10 diag kept over warm reset");
        por_n = 1'b0;
        idle(1);
        por_n = 1'b1;
        rd_reg(A_DIAG, 8'h00, "R10 diag cleared by power-on reset");

        idle(2);
        if (sb.size() != 0) begin
            checks++; errors++;
            $display("FAIL R2: %0d reads without data, expected 0", sb.size());
        end
        finish_run();
    end

endmodule